// File: doc/BRIEF.md
# High-Priority Interrupt Status Controller

This block collects high-priority interrupt causes into a sticky status register that the host can read. Each cause arrives as a single-cycle event pulse. The pulse is recorded only when the matching bit of the enable vector is set. The interrupt line is raised while any recorded cause is also enabled. The host acknowledges a cause by writing a one to its bit, which clears it. Writing a zero leaves a bit as it is.

A subset of the causes, selected by a parameter mask, are message-error causes. When one of them is recorded, the block asserts a hold signal that freezes the message engine. The hold stays asserted until the host has cleared every recorded error cause. Causes outside the mask raise the interrupt but never touch the hold. Which upstream conditions count as errors is decided outside this block.

The hold is driven by a two-state machine:
- `HS_RUN`: the engine is free to run.
- `HS_HOLD`: the engine is frozen.

It has two named transitions:
- ENTER (`HS_RUN` to `HS_HOLD`): taken when the next status value contains an error bit.
- RELEASE (`HS_HOLD` to `HS_RUN`): taken when the next status value contains no error bit.

Both transitions take effect at the same clock edge as the status update that causes them.

Top module: `hpi_status_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `status_o` is all zeros, and `irq_o` and `hold_o` are 0.
- R2: An event pulse on cause i with `en_i[i]`=1 sets `status_o[i]` at the next rising clock edge. The bit then stays set with no further events.
- R3: An event pulse on cause i with `en_i[i]`=0 leaves `status_o[i]` unchanged.
- R4: `irq_o` is 1 exactly when some bit i has both `status_o[i]`=1 and `en_i[i]`=1.
- R5: A host write (`wr_en_i`=1) clears, at the next edge, every status bit whose `wr_data_i` bit is 1. Bits whose `wr_data_i` bit is 0 keep their value.
- R6: If an enabled event and a host clear hit the same bit in the same cycle, the bit is set after the edge.
- R7: When an error cause (a bit set in `ERR_MASK`; by default bits 0 and 1) is recorded, `hold_o` rises at the same edge that sets its status bit.
- R8: `hold_o` stays 1 while any error bit of `status_o` is set. It falls at the edge where the last one is cleared.
- R9: A recorded cause outside `ERR_MASK` never asserts `hold_o`.
- R10: Clearing `en_i[i]` while `status_o[i]` is set keeps the status bit and only masks `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CAUSES | Per-cause event pulses |
| en_i | input | NUM_CAUSES | Interrupt enable vector |
| wr_en_i | input | 1 | Host write strobe for the status/reset register |
| wr_data_i | input | NUM_CAUSES | Host write data; a one clears the matching status bit |
| status_o | output | NUM_CAUSES | Status register, readable by the host |
| irq_o | output | 1 | High-priority interrupt line |
| hold_o | output | 1 | Freeze request to the message engine |

## Verification
A status bit that is lost or sticks wrongly shows on `status_o` one edge after the pulse or write that should have changed it. `irq_o` follows `status_o` in that same cycle. A hold machine in the wrong state shows on `hold_o` at the edge where an error bit is set or cleared. That makes the same-edge relation between the error bits of `status_o` and `hold_o` the sharpest observation point. The bench compares all three outputs in every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    // Hold machine states
    typedef enum logic [0:0] {
        HS_RUN  = 1'b0,
        HS_HOLD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/hpi_status_bit.sv
// One sticky status bit: set by an enabled event, cleared by a host write of one.
// A set request wins over a clear request in the same cycle.
module hpi_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o,
    output logic d_o
);

    logic bit_q;

    always_comb begin
        d_o = set_i | (bit_q & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= d_o;
        end
    end

    assign q_o = bit_q;

endmodule

// File: rtl/hpi_hold_fsm.sv
// Two-state hold machine. ENTER when the next status holds an error bit,
// RELEASE when it holds none.
module hpi_hold_fsm
    import hpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_pend_next_i,
    output logic hold_o
);

    hold_state_e state_q;
    hold_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN: begin
                if (err_pend_next_i) begin
                    state_d = HS_HOLD;   // ENTER
                end
            end
            HS_HOLD: begin
                if (!err_pend_next_i) begin
                    state_d = HS_RUN;    // RELEASE
                end
            end
            default: state_d = HS_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            HS_RUN:  hold_o = 1'b0;
            HS_HOLD: hold_o = 1'b1;
            default: hold_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/hpi_irq_reduce.sv
// Interrupt line: any status bit that is also enabled.
module hpi_irq_reduce #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] en_i,
    output logic             irq_o
);

    logic [WIDTH-1:0] live;

    always_comb begin
        live  = status_i & en_i;
        irq_o = |live;
    end

endmodule

// File: rtl/hpi_status_ctrl.sv
// High-priority interrupt status controller: top level.
module hpi_status_ctrl #(
    parameter int unsigned                 NUM_CAUSES = 8,
    parameter logic [NUM_CAUSES-1:0]       ERR_MASK   = 8'b0000_0011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] evt_i,
    input  logic [NUM_CAUSES-1:0] en_i,
    input  logic                  wr_en_i,
    input  logic [NUM_CAUSES-1:0] wr_data_i,
    output logic [NUM_CAUSES-1:0] status_o,
    output logic                  irq_o,
    output logic                  hold_o
);

    localparam int unsigned NC = NUM_CAUSES;

    logic [NC-1:0] set_req;
    logic [NC-1:0] clr_req;
    logic [NC-1:0] status_q;
    logic [NC-1:0] status_d;
    logic          err_pend_next;

    always_comb begin
        set_req = evt_i & en_i;
        clr_req = wr_data_i & {NC{wr_en_i}};
    end

    for (genvar gi = 0; gi < NC; gi++) begin : g_bit
        hpi_status_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_req[gi]),
            .clr_i (clr_req[gi]),
            .q_o   (status_q[gi]),
            .d_o   (status_d[gi])
        );
    end

    always_comb begin
        err_pend_next = |(status_d & ERR_MASK);
    end

    hpi_hold_fsm u_hold (
        .clk             (clk),
        .rst_n           (rst_n),
        .err_pend_next_i (err_pend_next),
        .hold_o          (hold_o)
    );

    hpi_irq_reduce #(
        .WIDTH (NC)
    ) u_irq (
        .status_i (status_q),
        .en_i     (en_i),
        .irq_o    (irq_o)
    );

    assign status_o = status_q;

endmodule

// File: rtl/hpi_status_ctrl_chk.sv
// Checker for hpi_status_ctrl, attached with bind below.
module hpi_status_ctrl_chk #(
    parameter int unsigned           NUM_CAUSES = 8,
    parameter logic [NUM_CAUSES-1:0] ERR_MASK   = 8'b0000_0011
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CAUSES-1:0] evt_i,
    input logic [NUM_CAUSES-1:0] en_i,
    input logic                  wr_en_i,
    input logic [NUM_CAUSES-1:0] wr_data_i,
    input logic [NUM_CAUSES-1:0] status_o,
    input logic                  irq_o,
    input logic                  hold_o
);

    // R2, R6: an enabled event always lands, even against a clear
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & en_i) |=> ((status_o & $past(evt_i & en_i)) == $past(evt_i & en_i)));

    // R3: no bit rises without an enabled event
    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(evt_i & en_i)) == '0));

    // R4: interrupt line tracks enabled status
    assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(status_o & en_i)));

    // R5: a clear without a competing event empties the bit
    assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((status_o & $past(wr_data_i & ~(evt_i & en_i))) == '0));

    // R7, R8, R9: hold follows the error bits of the status register
    assert_hold_tracks_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o == (|(status_o & ERR_MASK)));

    // R1: after reset nothing is pending
    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && !hold_o));

endmodule

bind hpi_status_ctrl hpi_status_ctrl_chk #(
    .NUM_CAUSES (NUM_CAUSES),
    .ERR_MASK   (ERR_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .en_i      (en_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .status_o  (status_o),
    .irq_o     (irq_o),
    .hold_o    (hold_o)
);

// File: tb/hpi_status_ctrl_bench.sv
module hpi_status_ctrl_bench;

    localparam int unsigned     NC  = 8;
    localparam logic [NC-1:0]   ERR = 8'b0000_0011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] evt = '0;
    logic [NC-1:0] en = '0;
    logic          wr_en = 1'b0;
    logic [NC-1:0] wr_data = '0;
    logic [NC-1:0] status;
    logic          irq;
    logic          hold;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [NC-1:0] st;
        logic          irq;
        logic          hold;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [NC-1:0] model_st = '0;

    always #2 clk = ~clk;   // 250 MHz

    hpi_status_ctrl #(
        .NUM_CAUSES (NC),
        .ERR_MASK   (ERR)
    ) u_hpi_status_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .en_i      (en),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .status_o  (status),
        .irq_o     (irq),
        .hold_o    (hold)
    );

    task automatic check(input string tag, input logic [NC-1:0] act_st,
                         input logic act_irq, input logic act_hold,
                         input logic [NC-1:0] e_st, input logic e_irq,
                         input logic e_hold);
        n_checks++;
        if (act_st !== e_st || act_irq !== e_irq || act_hold !== e_hold) begin
            n_fails++;
            $display("FAIL %s: status=%h irq=%b hold=%b, expected status=%h irq=%b hold=%b",
                     tag, act_st, act_irq, act_hold, e_st, e_irq, e_hold);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input logic [NC-1:0] e_vec, input logic [NC-1:0] en_vec,
                        input logic w, input logic [NC-1:0] wd, input string tag);
        exp_t it;
        @(negedge clk);
        evt     = e_vec;
        en      = en_vec;
        wr_en   = w;
        wr_data = wd;
        model_st = (model_st & ~(w ? wd : '0)) | (e_vec & en_vec);
        it.st   = model_st;
        it.irq  = |(model_st & en_vec);
        it.hold = |(model_st & ERR);
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare once per edge, away from the edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check(it.tag, status, irq, hold, it.st, it.irq, it.hold);
        end
    end

    initial begin
        #40000;
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", status, irq, hold, '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        step(8'h00, 8'hFF, 1'b0, 8'h00, "R1 after reset");
        // R2, R9: non-error cause sets status and irq, no hold
        step(8'h10, 8'hFF, 1'b0, 8'h00, "R2 R9 set bit4");
        step(8'h00, 8'hFF, 1'b0, 8'h00, "R2 sticky");
        // R5: write of zero keeps, write of one clears
        step(8'h00, 8'hFF, 1'b1, 8'hEF, "R5 zero keeps");
        step(8'h00, 8'hFF, 1'b1, 8'h10, "R5 one clears");
        // R3: disabled cause ignored
        step(8'h08, 8'hF7, 1'b0, 8'h00, "R3 disabled event");
        step(8'h00, 8'hFF, 1'b0, 8'h00, "R3 still clear");
        // R7, R8: error causes and hold
        step(8'h01, 8'hFF, 1'b0, 8'h00, "R7 error enters hold");
        step(8'h00, 8'hFF, 1'b0, 8'h00, "R8 hold persists");
        step(8'h02, 8'hFF, 1'b0, 8'h00, "R7 second error");
        step(8'h00, 8'hFF, 1'b1, 8'h01, "R8 one error left");
        step(8'h00, 8'hFF, 1'b1, 8'h02, "R8 last error cleared");
        // R6: set wins over clear
        step(8'h20, 8'hFF, 1'b0, 8'h00, "R2 set bit5");
        step(8'h20, 8'hFF, 1'b1, 8'h20, "R6 set beats clear");
        step(8'h00, 8'hFF, 1'b1, 8'h20, "R5 clear bit5");
        // R10, R4: enable drop masks irq only
        step(8'h40, 8'hFF, 1'b0, 8'h00, "R4 set bit6");
        step(8'h00, 8'hBF, 1'b0, 8'h00, "R10 masked irq");
        step(8'h00, 8'hFF, 1'b0, 8'h00, "R4 unmasked irq");
        step(8'h00, 8'hFF, 1'b1, 8'h40, "R5 clear bit6");
        // R3, R7: disabled error cause does not hold
        step(8'h01, 8'hFE, 1'b0, 8'h00, "R3 disabled error");
        // R6, R8: fresh error against its clear keeps hold
        step(8'h01, 8'hFF, 1'b0, 8'h00, "R7 error again");
        step(8'h01, 8'hFF, 1'b1, 8'h01, "R6 R8 hold kept");
        step(8'h00, 8'hFF, 1'b1, 8'h01, "R8 release");
        // R9: several non-error causes together
        step(8'hFC, 8'hFF, 1'b0, 8'h00, "R9 many non-error");
        step(8'h00, 8'hFF, 1'b1, 8'hFF, "R5 clear all");
        step(8'h00, 8'hFF, 1'b0, 8'h00, "R1 idle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule